// File: doc/BRIEF.md
# Programmable CAS Waveform Sequencer

This block generates the row and column strobes for one asynchronous DRAM burst from a bit pattern that software programs. The pattern is 96 bits long and is held in three 32-bit registers that can be read and written. It is stepped out one bit per step, starting at bit 0. A 0 bit drives the active-low column strobe low for that step, and a 1 bit drives it high. When the last bit has been used, the pattern wraps back to bit 0 and continues until the burst is finished.

A burst begins when a start request arrives with a non-zero beat count. The row strobe falls and stays low while the block counts completed column pulses against the requested count. After the column strobe rises at the end of the last pulse, the row strobe is held low for one more step. It is then released, and a one-clock done flag marks that cycle.

The step length is one clock or two clocks, chosen by two configuration inputs. In the one-clock mode the pattern must obey timing rules. If a burst starts in that mode with a pattern that breaks them, a sticky error flag is set.

Top module: `cas_wave_seq`

## Requirements
- R1: After reset both strobes are high (idle), done and the error flag are 0, and register 0 reads 0x0000057F while registers 1 and 2 read 0.
- R2: Register address 0 holds pattern bits 31..0, address 1 holds bits 63..32 and address 2 holds bits 95..64. Address 3 reads 0 and a write to it has no effect. Read data follows the address combinationally at all times.
- R3: A start with a non-zero beat count, accepted while idle at a clock edge, pulls the row strobe low in the next cycle. Pattern bit 0 is output in that first step, and each later step outputs the next higher bit.
- R4: While a burst is running, the column strobe equals the pattern bit of the current step (0 drives the strobe low, 1 drives it high).
- R5: A pulse is complete at a step boundary where the current bit is 0 and the next bit is 1. When the completed pulse is the last of the requested count, the column strobe stays high for one more step and the row strobe rises at the end of that step.
- R6: After bit 95 the pattern continues at bit 0 and keeps rotating until the burst completes.
- R7: A step lasts one clock when both the double-step input and the half-width input are 0. It lasts two clocks when either of them is 1. Both inputs are sampled when the burst starts.
- R8: A start accepted in one-clock mode sets the sticky error flag if pattern bits 3..0 are not all 1, or if any bit differs from both of its cyclic neighbours (a run shorter than 2 clocks). Only reset clears the flag.
- R9: Register writes are ignored while a burst is active. A write in the same cycle as an accepted start is stored.
- R10: The done output is high for exactly one clock, in the cycle in which the row strobe has returned high after a burst.
- R11: A start with a beat count of 0 is ignored, and so is a start during an active burst. The strobes and busy are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| dbl_step_i | input | 1 | Two clocks per step when 1 |
| half_width_i | input | 1 | Half-width bus; forces two clocks per step |
| start_i | input | 1 | Burst start request |
| beats_i | input | 8 | Number of column pulses in the burst |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock burst completion pulse |
| cfg_err_o | output | 1 | Sticky pattern rule violation |

## Verification
The bench runs bursts whose pulses fall near the end of the pattern, and bursts that need more than one full rotation. A sequencer that miscounted the wrap would stall or skip pulses there. It measures how long the busy window lasts in one-clock, double-step and half-width mode, which exposes a wrong step length or a half-width input that does not override. It writes registers in the middle of a burst and issues zero-count and overlapping starts. A design that let these through would change the waveform or restart the burst. It also starts the reset pattern in one-clock mode so that the error flag must rise and stay set, while legal patterns must leave it clear.

// File: rtl/cas_wave_pkg.sv
package cas_wave_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_st_e;
endpackage

// File: rtl/cas_wave_regs.sv
module cas_wave_regs
  import cas_wave_pkg::*;
#(
  parameter int unsigned NREG   = 3,
  parameter int unsigned ADDR_W = 2,
  parameter logic [REG_W-1:0] RST0 = 32'h0000_057F,
  localparam int unsigned WAVE_W = NREG * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [WAVE_W-1:0] pat_o
);
  logic [REG_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] RV = (g == 0) ? RST0 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= RV;
      end else if (we_i && !lock_i && (32'(addr_i) == g)) begin
        regs_q[g] <= wdata_i;
      end
    end
    assign pat_o[g*REG_W +: REG_W] = regs_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (32'(addr_i) == i) rdata_o = regs_q[i];
    end
  end
endmodule

// File: rtl/cas_wave_rules.sv
module cas_wave_rules #(
  parameter int unsigned WAVE_W   = 96,
  parameter int unsigned LEAD_ONE = 4
) (
  input  logic [WAVE_W-1:0] pat_i,
  output logic              bad_o
);
  logic [WAVE_W-1:0] lone;

  // a bit unlike both cyclic neighbours is a one-clock run
  for (genvar g = 0; g < WAVE_W; g++) begin : g_lone
    localparam int unsigned PV = (g == 0) ? WAVE_W - 1 : g - 1;
    localparam int unsigned NX = (g == WAVE_W - 1) ? 0 : g + 1;
    assign lone[g] = (pat_i[g] != pat_i[PV]) && (pat_i[g] != pat_i[NX]);
  end

  assign bad_o = (|lone) || !(&pat_i[LEAD_ONE-1:0]);
endmodule

// File: rtl/cas_wave_step.sv
module cas_wave_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic two_i,
  input  logic run_i,
  output logic step_end_o
);
  logic two_q, ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      two_q <= 1'b0;
      ph_q  <= 1'b0;
    end else if (load_i) begin
      two_q <= two_i;
      ph_q  <= 1'b0;
    end else if (run_i && two_q) begin
      ph_q <= ~ph_q;
    end else begin
      ph_q <= 1'b0;
    end
  end

  assign step_end_o = run_i && (!two_q || ph_q);
endmodule

// File: rtl/cas_wave_ctrl.sv
module cas_wave_ctrl
  import cas_wave_pkg::*;
#(
  parameter int unsigned WAVE_W = 96,
  parameter int unsigned BEAT_W = 8,
  localparam int unsigned IDX_W = $clog2(WAVE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              two_i,
  input  logic              bad_i,
  input  logic              step_end_i,
  input  logic [WAVE_W-1:0] pat_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              done_o,
  output logic              err_o
);
  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q, idx_nx;
  logic [BEAT_W-1:0] beats_q;
  logic              done_q, err_q;
  logic              cur_bit, nxt_bit, pulse_end;

  assign load_o    = (st_q == ST_IDLE) && start_i && (beats_i != '0);
  assign idx_nx    = (idx_q == IDX_W'(WAVE_W - 1)) ? '0 : idx_q + 1'b1;
  assign cur_bit   = pat_i[idx_q];
  assign nxt_bit   = pat_i[idx_nx];
  assign pulse_end = step_end_i && !cur_bit && nxt_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      beats_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_o) begin
            st_q    <= ST_RUN;
            idx_q   <= '0;
            beats_q <= beats_i;
            if (!two_i && bad_i) err_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (step_end_i) idx_q <= idx_nx;
          if (pulse_end) begin
            if (beats_q == BEAT_W'(1)) st_q <= ST_TAIL;
            else beats_q <= beats_q - 1'b1;
          end
        end
        ST_TAIL: begin
          if (step_end_i) begin
            st_q   <= ST_IDLE;
            idx_q  <= idx_nx;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign ras_n_o = !busy_o;
  assign cas_n_o = (st_q == ST_RUN) ? cur_bit : 1'b1;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/cas_wave_seq.sv
module cas_wave_seq
  import cas_wave_pkg::*;
#(
  parameter int unsigned NREG   = 3,
  parameter int unsigned BEAT_W = 8,
  localparam int unsigned ADDR_W = 2,
  localparam int unsigned WAVE_W = NREG * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              dbl_step_i,
  input  logic              half_width_i,
  input  logic              start_i,
  input  logic [BEAT_W-1:0] beats_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  logic [WAVE_W-1:0] pat;
  logic bad, load, step_end, two;

  // half-width forces the slow step regardless of the double-step bit
  assign two = half_width_i | dbl_step_i;

  cas_wave_regs #(.NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .lock_i(busy_o), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .pat_o(pat)
  );

  cas_wave_rules #(.WAVE_W(WAVE_W)) u_rules (.pat_i(pat), .bad_o(bad));

  cas_wave_step u_step (
    .clk_i, .rst_ni, .load_i(load), .two_i(two), .run_i(busy_o),
    .step_end_o(step_end)
  );

  cas_wave_ctrl #(.WAVE_W(WAVE_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .beats_i, .two_i(two), .bad_i(bad),
    .step_end_i(step_end), .pat_i(pat), .load_o(load), .busy_o,
    .ras_n_o, .cas_n_o, .done_o, .err_o(cfg_err_o)
  );
endmodule

module cas_wave_seq_chk #(
  parameter int unsigned BEAT_W = 8,
  parameter int unsigned WAVE_W = 96
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [BEAT_W-1:0] beats_i,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              cfg_err_o,
  input logic [WAVE_W-1:0] pat
);
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && cas_n_o));
  // R10
  done_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_n_o && !$past(ras_n_o)));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  release_after_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $past(cas_n_o));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  // R9
  locked_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pat));
  // R11
  zero_beats_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && beats_i == '0) |=> !busy_o);
endmodule

bind cas_wave_seq cas_wave_seq_chk #(.BEAT_W(BEAT_W), .WAVE_W(WAVE_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .beats_i, .ras_n_o, .cas_n_o, .busy_o,
  .done_o, .cfg_err_o, .pat
);

// File: tb/tb_cas_wave_seq.sv
module tb_cas_wave_seq;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we = 1'b0, dbl = 1'b0, hw = 1'b0, start = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  beats = '0;
  logic        ras_n, cas_n, busy, done, err;

  int vecs = 0, bad = 0, cyc = 0;
  string scen = "R1";

  cas_wave_seq dut (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dbl_step_i(dbl),
    .half_width_i(hw), .start_i(start), .beats_i(beats), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .busy_o(busy), .done_o(done), .cfg_err_o(err)
  );

  always #10 clk = ~clk;

  // reference model
  logic [95:0] m_pat;
  int m_st, m_idx, m_sub, m_beats;
  bit m_two, m_done, m_err;

  function automatic bit rule_broken(logic [95:0] p);
    if (p[3:0] != 4'hF) return 1;
    for (int i = 0; i < 96; i++) begin
      if (p[i] != p[(i + 95) % 96] && p[i] != p[(i + 1) % 96]) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pat = 96'h57F; m_st = 0; m_idx = 0; m_sub = 0; m_beats = 0;
      m_two = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (start && beats != 0) begin
          m_st = 1; m_idx = 0; m_sub = 0; m_two = dbl | hw; m_beats = beats;
          if (!m_two && rule_broken(m_pat)) m_err = 1;
        end
        if (reg_we && addr != 3) m_pat[addr*32 +: 32] = wdata;
      end else begin
        bit stp;
        stp = !m_two || m_sub == 1;
        m_sub = m_two ? 1 - m_sub : 0;
        if (stp) begin
          if (m_st == 2) begin
            m_st = 0; m_done = 1;
          end else if (!m_pat[m_idx] && m_pat[(m_idx + 1) % 96]) begin
            if (m_beats == 1) m_st = 2; else m_beats--;
          end
          m_idx = (m_idx + 1) % 96;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s act=%h exp=%h cyc=%0d", req, scen, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      chk("R5", "ras_n", 32'(ras_n), 32'(m_st == 0));
      chk("R4", "cas_n", 32'(cas_n), 32'((m_st == 1) ? m_pat[m_idx] : 1'b1));
      chk("R3", "busy", 32'(busy), 32'(m_st != 0));
      chk("R10", "done", 32'(done), 32'(m_done));
      chk("R8", "err", 32'(err), 32'(m_err));
      chk("R2", "rdata", rdata, (addr == 3) ? 32'h0 : m_pat[addr*32 +: 32]);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    reg_we = 1; addr = 2'(a); wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic burst(int n, bit d, bit h, output int len);
    dbl = d; hw = h; beats = 8'(n); start = 1;
    @(negedge clk);
    start = 0; len = 0;
    while (busy && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    scen = "R1";
    chk("R1", "ras_n reset", 32'(ras_n), 1);
    chk("R1", "cas_n reset", 32'(cas_n), 1);
    addr = 0; #1; chk("R1", "reg0 reset", rdata, 32'h57F);
    addr = 1; #1; chk("R1", "reg1 reset", rdata, 0);
    addr = 3; #1; chk("R2", "addr3 read", rdata, 0);
    @(negedge clk);

    scen = "R2";
    wr(3, 32'hDEAD_BEEF);
    wr(0, 32'h3333_333F); wr(1, 32'h3333_3333); wr(2, 32'h3333_3333);
    addr = 2; #1; chk("R2", "reg2 readback", rdata, 32'h3333_3333);

    scen = "R7";
    burst(1, 0, 0, len); chk("R7", "single len b1", len, 9);
    burst(3, 0, 0, len); chk("R7", "single len b3", len, 17);
    burst(1, 1, 0, len); chk("R7", "double len", len, 18);
    burst(1, 0, 1, len); chk("R7", "half-width len", len, 18);
    chk("R8", "legal pattern no err", 32'(err), 0);

    scen = "R6";
    wr(0, 32'h00F0_000F); wr(1, 32'h0); wr(2, 32'hFF00_0000);
    burst(3, 0, 0, len);
    burst(2, 1, 1, len);

    scen = "R9";
    wr(0, 32'h3333_333F); wr(1, 32'h3333_3333); wr(2, 32'h3333_3333);
    dbl = 1; beats = 8'd4; start = 1;
    @(negedge clk);
    start = 0;
    wr(0, 32'h0); wr(1, 32'h1234_5678);
    addr = 0; #1; chk("R9", "locked reg0", rdata, 32'h3333_333F);
    scen = "R11";
    start = 1; beats = 8'd9;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    beats = 8'd0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R11", "zero beats idle", 32'(busy), 0);

    scen = "R3";
    reg_we = 1; addr = 0; wdata = 32'hC333_333F; start = 1; beats = 8'd2; dbl = 0;
    @(negedge clk);
    reg_we = 0; start = 0;
    chk("R3", "first step bit0", 32'(cas_n), 1);
    addr = 0; #1; chk("R9", "write with start stored", rdata, 32'hC333_333F);
    while (busy) @(negedge clk);

    scen = "R8";
    wr(0, 32'h57F);
    burst(1, 0, 0, len);
    chk("R8", "err set", 32'(err), 1);
    burst(1, 1, 0, len);
    chk("R8", "err sticky", 32'(err), 1);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule